// File: doc/BRIEF.md
# Aperture Address Remapper

This block translates the addresses of one bus master before they reach the interconnect. The 4 GB address space is split into sixteen 256 MB apertures. Each aperture names a target slave port and a 256 MB window inside that slave. The top four address bits choose the aperture. They are then replaced by the programmed window index, and the lower 28 bits pass through unchanged. An aperture whose slave port is zero has nothing mapped to it. A request that lands there is flagged as a decode error, and the fabric turns that flag into an error response.

Software programs the map through a simple write port into shadow registers. A write of 1 to the commit register copies the whole shadow map into the active map in one clock. Requests in flight therefore never see a map that is half old and half new. Each request presented with `req_valid` produces a registered result one clock later.

Top module: `aperture_remap`

## Requirements
- R1: After reset, the active map and the shadow map are the identity: every aperture selects port 1 with window index equal to its own number. `rsp_valid` is 0 while reset is held, and all outputs are 0.
- R2: `rsp_valid` equals `req_valid` from the previous clock. The result fields change only on a clock where `req_valid` was 1, and otherwise hold their value.
- R3: `rsp_addr[27:0]` equals `req_addr[27:0]`. `rsp_addr[31:28]` is the window index of the aperture selected by `req_addr[31:28]`.
- R4: Port-select fields are written at byte offset 0x0 for apertures 0 to 7 and at 0x4 for apertures 8 to 15. Aperture i uses data bits [4*(i mod 8)+3 : 4*(i mod 8)].
- R5: Window-index fields are written at offset 0x8 for apertures 0 to 7 and at 0xC for apertures 8 to 15, with the same nibble packing as R4.
- R6: Shadow writes have no effect on translation until a commit, which is a write to offset 0x10 with data bit 0 set.
- R7: A write to offset 0x10 with data bit 0 clear does not change the active map. A write to any offset other than 0x0, 0x4, 0x8, 0xC or 0x10 changes neither map.
- R8: A commit copies all sixteen port selects and window indices into the active map on the same clock. Requests presented from the next clock onward use the new map.
- R9: A request to an aperture whose active port select is 0 gives `rsp_decerr` = 1 and `rsp_slave` = 0. Any other request gives `rsp_decerr` = 0.
- R10: Shadow writes made after a commit leave the committed map in use until the next commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 5 | Byte offset of the configuration write |
| cfg_wr_data | input | 32 | Configuration write data |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 32 | Master-side request address |
| rsp_valid | output | 1 | Result valid, one clock after the request |
| rsp_slave | output | 4 | Target slave port (0 on decode error) |
| rsp_addr | output | 32 | Translated slave-side address |
| rsp_decerr | output | 1 | Request hit an unmapped aperture |

## Verification
The hardest case to reach from the ports is a window in which the shadow map and the active map differ. Only in that window can a premature or partial commit be seen. The stimulus fills all four shadow registers with values that differ from the identity, including zero port selects. It then sweeps all sixteen apertures before any commit, after a commit write with bit 0 clear, and after a write to an unused offset. It then commits and sweeps again, and finally rewrites the shadow without committing. The bench model keeps its own shadow and active tables, so any leak between them shows up as a mismatch in the affected aperture.

// File: rtl/remap_pkg.sv
package remap_pkg;
  // Default geometry of the remapper
  localparam int ADDR_W    = 32;
  localparam int APER_BITS = 4;
  localparam int NUM_APER  = 1 << APER_BITS;
  localparam int DATA_W    = 32;
  localparam int OFS_W     = 5;
  localparam int FIELD_W   = APER_BITS;
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs #(
  parameter int DATA_W   = remap_pkg::DATA_W,
  parameter int FIELD_W  = remap_pkg::FIELD_W,
  parameter int NUM_APER = remap_pkg::NUM_APER,
  parameter int OFS_W    = remap_pkg::OFS_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [OFS_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NUM_APER*FIELD_W-1:0]  act_sel,
  output logic [NUM_APER*FIELD_W-1:0]  act_off
);
  localparam int PER_REG = DATA_W / FIELD_W;
  localparam int NREG    = NUM_APER / PER_REG;
  localparam int WORD_W  = OFS_W - 2;
  localparam int UPD_IDX = 2 * NREG;

  logic [FIELD_W-1:0] sh_sel [NUM_APER];
  logic [FIELD_W-1:0] sh_off [NUM_APER];
  logic [FIELD_W-1:0] ac_sel [NUM_APER];
  logic [FIELD_W-1:0] ac_off [NUM_APER];

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              commit;

  assign word    = wr_addr[OFS_W-1:2];
  assign aligned = (wr_addr[1:0] == 2'b00);
  assign commit  = wr_en && aligned && (word == WORD_W'(UPD_IDX)) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_APER; i++) begin
        sh_sel[i] <= FIELD_W'(1);
        sh_off[i] <= FIELD_W'(i);
        ac_sel[i] <= FIELD_W'(1);
        ac_off[i] <= FIELD_W'(i);
      end
    end else begin
      if (wr_en && aligned) begin
        for (int r = 0; r < NREG; r++) begin
          for (int k = 0; k < PER_REG; k++) begin
            if (word == WORD_W'(r))
              sh_sel[r*PER_REG+k] <= wr_data[k*FIELD_W +: FIELD_W];
            if (word == WORD_W'(NREG + r))
              sh_off[r*PER_REG+k] <= wr_data[k*FIELD_W +: FIELD_W];
          end
        end
      end
      if (commit) begin
        for (int i = 0; i < NUM_APER; i++) begin
          ac_sel[i] <= sh_sel[i];
          ac_off[i] <= sh_off[i];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_APER; g++) begin : g_pack
    assign act_sel[g*FIELD_W +: FIELD_W] = ac_sel[g];
    assign act_off[g*FIELD_W +: FIELD_W] = ac_off[g];
  end

  // R6 / R7 / R10: the active map moves only on a commit
  a_r6_active_held: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(act_sel) && $stable(act_off)));
endmodule

// File: rtl/remap_lookup.sv
module remap_lookup #(
  parameter int ADDR_W    = remap_pkg::ADDR_W,
  parameter int APER_BITS = remap_pkg::APER_BITS,
  parameter int NUM_APER  = remap_pkg::NUM_APER
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_APER*APER_BITS-1:0] sel_vec,
  input  logic [NUM_APER*APER_BITS-1:0] off_vec,
  output logic [APER_BITS-1:0]          slave,
  output logic [ADDR_W-1:0]             xaddr,
  output logic                          decerr
);
  localparam int LOW_W = ADDR_W - APER_BITS;

  logic [APER_BITS-1:0] ap;
  logic [APER_BITS-1:0] sel;
  logic [APER_BITS-1:0] off;

  always_comb begin
    ap     = addr[ADDR_W-1 -: APER_BITS];
    sel    = sel_vec[ap*APER_BITS +: APER_BITS];
    off    = off_vec[ap*APER_BITS +: APER_BITS];
    decerr = (sel == '0);
    slave  = sel;
    xaddr  = {off, addr[LOW_W-1:0]};
  end
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap #(
  parameter int ADDR_W    = remap_pkg::ADDR_W,
  parameter int APER_BITS = remap_pkg::APER_BITS,
  parameter int DATA_W    = remap_pkg::DATA_W,
  parameter int OFS_W     = remap_pkg::OFS_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr_en,
  input  logic [OFS_W-1:0]     cfg_wr_addr,
  input  logic [DATA_W-1:0]    cfg_wr_data,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 rsp_valid,
  output logic [APER_BITS-1:0] rsp_slave,
  output logic [ADDR_W-1:0]    rsp_addr,
  output logic                 rsp_decerr
);
  localparam int NUM_APER = 1 << APER_BITS;
  localparam int LOW_W    = ADDR_W - APER_BITS;

  logic [NUM_APER*APER_BITS-1:0] act_sel;
  logic [NUM_APER*APER_BITS-1:0] act_off;
  logic [APER_BITS-1:0]          lk_slave;
  logic [ADDR_W-1:0]             lk_addr;
  logic                          lk_decerr;

  remap_cfg_regs #(
    .DATA_W(DATA_W), .FIELD_W(APER_BITS), .NUM_APER(NUM_APER), .OFS_W(OFS_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .act_sel(act_sel), .act_off(act_off)
  );

  remap_lookup #(
    .ADDR_W(ADDR_W), .APER_BITS(APER_BITS), .NUM_APER(NUM_APER)
  ) u_lookup (
    .addr(req_addr), .sel_vec(act_sel), .off_vec(act_off),
    .slave(lk_slave), .xaddr(lk_addr), .decerr(lk_decerr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_slave  <= '0;
      rsp_addr   <= '0;
      rsp_decerr <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_slave  <= lk_slave;
        rsp_addr   <= lk_addr;
        rsp_decerr <= lk_decerr;
      end
    end
  end

  // R2: one-clock latency, and the result is held while idle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && $stable(rsp_addr) && $stable(rsp_slave)));
  // R3: the low address bits are never altered
  a_r3_low_pass: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_addr[LOW_W-1:0] == $past(req_addr[LOW_W-1:0])));
  // R9: a decode error always reports port 0
  a_r9_decerr_port: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_decerr == (rsp_slave == '0)));
endmodule

// File: tb/aperture_remap_test.sv
module aperture_remap_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [4:0]  cfg_wr_addr = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_slave;
  logic [31:0] rsp_addr;
  logic        rsp_decerr;

  int n_checks = 0;
  int n_fail   = 0;
  string phase = "R1";

  // reference model state
  int sh_sel [16];
  int sh_off [16];
  int ac_sel [16];
  int ac_off [16];
  bit          e_valid = 0;
  int          e_slave = 0;
  logic [31:0] e_addr = '0;
  bit          e_dec = 0;

  always #10 clk = ~clk;

  aperture_remap uut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_slave(rsp_slave), .rsp_addr(rsp_addr),
    .rsp_decerr(rsp_decerr)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) begin
        sh_sel[i] = 1; sh_off[i] = i; ac_sel[i] = 1; ac_off[i] = i;
      end
      e_valid = 0; e_slave = 0; e_addr = '0; e_dec = 0;
    end else begin
      e_valid = req_valid;
      if (req_valid) begin
        int ap;
        ap = int'(req_addr[31:28]);
        e_slave = ac_sel[ap];
        e_dec   = (ac_sel[ap] == 0);
        e_addr  = {4'(ac_off[ap]), req_addr[27:0]};
      end
      if (cfg_wr_en) begin
        case (cfg_wr_addr)
          5'h00: for (int k = 0; k < 8; k++) sh_sel[k]   = int'((cfg_wr_data >> (4*k)) & 32'hF);
          5'h04: for (int k = 0; k < 8; k++) sh_sel[k+8] = int'((cfg_wr_data >> (4*k)) & 32'hF);
          5'h08: for (int k = 0; k < 8; k++) sh_off[k]   = int'((cfg_wr_data >> (4*k)) & 32'hF);
          5'h0C: for (int k = 0; k < 8; k++) sh_off[k+8] = int'((cfg_wr_data >> (4*k)) & 32'hF);
          5'h10: if (cfg_wr_data[0])
                   for (int i = 0; i < 16; i++) begin ac_sel[i] = sh_sel[i]; ac_off[i] = sh_off[i]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(rst ? "R1" : "R2", "rsp_valid", 32'(rsp_valid), 32'(e_valid));
    chk(rst ? "R1" : phase, "rsp_addr (R3)", rsp_addr, e_addr);
    chk(rst ? "R1" : phase, "rsp_slave", 32'(rsp_slave), 32'(e_slave));
    chk(e_dec ? "R9" : phase, "rsp_decerr", 32'(rsp_decerr), 32'(e_dec));
  end

  task automatic cfg_write(logic [4:0] ofs, logic [31:0] data);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_wr_addr = ofs; cfg_wr_data = data;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
  endtask

  task automatic request(int ap, int salt);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = {4'(ap), 28'(32'h0ABCDEF ^ (ap * 32'h1111113) ^ (salt * 32'h0357911))};
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic sweep(int salt);
    for (int a = 0; a < 16; a++) begin
      request(a, salt);
      if (a % 3 == 0) begin @(posedge clk); #1; end
    end
    @(posedge clk); #1;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog (all) actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    phase = "R1 R3";
    request(0, 1); request(15, 2); request(8, 3);
    sweep(4);
    // back-to-back requests without gaps
    phase = "R2 R3";
    @(posedge clk); #1; req_valid = 1; req_addr = 32'h1234_5678;
    @(posedge clk); #1; req_addr = 32'hFEDC_BA98;
    @(posedge clk); #1; req_valid = 0; req_addr = 32'h5555_5555;
    repeat (2) @(posedge clk); #1;
    // fill the shadow map; translation must stay identity
    phase = "R6";
    cfg_write(5'h00, 32'h3210_0421);
    cfg_write(5'h04, 32'h0703_6100);
    cfg_write(5'h08, 32'h89AB_CDEF);
    cfg_write(5'h0C, 32'h7654_3210);
    sweep(5);
    phase = "R7";
    cfg_write(5'h10, 32'hFFFF_FFFE);
    cfg_write(5'h14, 32'hFFFF_FFFF);
    cfg_write(5'h1C, 32'h0000_0001);
    sweep(6);
    phase = "R4 R5 R8 R9";
    cfg_write(5'h10, 32'h0000_0001);
    sweep(7);
    phase = "R10";
    cfg_write(5'h00, 32'h1111_1111);
    cfg_write(5'h0C, 32'hAAAA_AAAA);
    sweep(8);
    phase = "R8 R9";
    cfg_write(5'h10, 32'h0000_0001);
    sweep(9);
    repeat (3) @(posedge clk);
    finish_up();
  end
endmodule